// File: doc/BRIEF.md
# Bit-Serial Coefficient Quantizer with Reciprocal Step Table

This block turns a stream of transform coefficients into quantized integers. Each coefficient is 12 bits wide. It arrives one bit per clock, least significant bit first, in two's complement, and one word fills a 12-clock word cycle. A coefficient position from 0 to 63 goes with every word. The block uses that position to read an internal table, which holds the reciprocal of the quantization step for that position. A shift-and-add multiplier takes the serial bits one at a time and multiplies them by the parallel reciprocal, so the block needs no divider and no full array multiplier.

The product is rounded and saturated into an 11-bit signed result. The result leaves the block with a one-cycle valid strobe and the position it belongs to. Steps grow from the top-left corner of the 8x8 grid toward the bottom-right corner, so high-frequency positions are quantized more coarsely and often give zero. A per-word enable lets the upstream control skip positions it does not compute. For a skipped word the accumulator does not move and the result register keeps its last contents.

Top module: `qnt_serial_top`

## Requirements
- R1: During and after a synchronous active-low reset, q_valid is 0, q_out is 0 and q_pos is 0.
- R2: A word begins in the cycle where word_start is 1, and that cycle carries bit 0. Bits 1 to 11 follow on consecutive cycles, with bit 11 as the two's-complement sign bit. pos_idx and enable are taken in the word_start cycle, and pos_idx stays equal to that value for the whole word.
- R3: For position p, take row = p[5:3] and col = p[2:0]. The step is s = 1 + row + col, and the reciprocal is floor((65536 + floor(s/2)) / s), an unsigned value with 16 fractional bits.
- R4: The result is coefficient × reciprocal / 65536, rounded to the nearest integer, with an exact half rounded away from zero. For example, 3 at step 2 gives 2, and -3 at step 2 gives -2.
- R5: Results are saturated to the range -1024 to 1023.
- R6: For an enabled word, q_valid is 1 for exactly one cycle. That is the cycle right after the clock edge that samples bit 11, and in it q_out holds the result and q_pos holds the word's position.
- R7: For a word with enable at 0, q_valid stays 0, and q_out and q_pos keep the values they had before the word.
- R8: Words may follow each other with no idle cycle. The word_start of the next word then comes in the cycle right after bit 11 of the current word, and every result is still correct.
- R9: When no word is in progress, bit_in, pos_idx and enable are ignored while word_start is 0. They cause neither a strobe nor a change on q_out or q_pos.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_start | input | 1 | Marks bit 0 of a coefficient word |
| bit_in | input | 1 | Serial coefficient bit, LSB first |
| pos_idx | input | 6 | Coefficient position, row in bits 5:3, column in bits 2:0 |
| enable | input | 1 | 1 = quantize this word, 0 = skip it |
| q_out | output | 11 | Signed quantized result |
| q_valid | output | 1 | One-cycle strobe for a new result |
| q_pos | output | 6 | Position of the result on q_out |

## Verification
Two things can happen in one cycle when words run back to back. The result register loads from the final sign-bit subtraction, and the accumulator restarts on bit 0 of the next word. The bench provokes this with runs of words that have no gap between them, some of them skipped and some with idle gaps. A scoreboard compares every strobed result and position, in order, against values it computes from the step formula. After each skipped word it also checks that the outputs held their values and that no extra strobe appeared.

// File: rtl/qnt_pkg.sv
// Package: shared helpers for the serial quantizer.
// Assumes the step of a position grows by one per row and per column.
package qnt_pkg;

    // Reciprocal of the step at position pos, rounded to nearest, with frac_w fractional bits.
    function automatic int recip_of(input int pos, input int col_w, input int frac_w);
        int row;
        int col;
        int step;
        row  = pos >> col_w;
        col  = pos & ((1 << col_w) - 1);
        step = 1 + row + col;
        return ((1 << frac_w) + step / 2) / step;
    endfunction

endpackage

// File: rtl/qnt_recip_rom.sv
// Module: reciprocal step table.
// Holds one unsigned fixed-point reciprocal per coefficient position.
// The table is built at elaboration. The read is combinational.
module qnt_recip_rom #(
    parameter int POS_W   = 6,
    parameter int FRAC_W  = 16,
    parameter int RECIP_W = FRAC_W + 1
) (
    input  logic [POS_W-1:0]   addr,
    output logic [RECIP_W-1:0] recip
);
    localparam int DEPTH = 1 << POS_W;
    localparam int COL_W = POS_W / 2;

    logic [RECIP_W-1:0] tbl [DEPTH];

    // One constant entry per position.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign tbl[i] = RECIP_W'(qnt_pkg::recip_of(i, COL_W, FRAC_W));
    end

    // Table read.
    assign recip = tbl[addr];
endmodule

// File: rtl/qnt_serial_mac.sv
// Module: shift-and-add serial-by-parallel multiplier.
// Each serial bit adds the reciprocal shifted left by the bit's weight.
// The sign bit (last) subtracts it instead.
// acc_next is the value after the current bit, available combinationally.
module qnt_serial_mac #(
    parameter int RECIP_W = 17,
    parameter int ACC_W   = 30,
    parameter int CNT_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic                    first,
    input  logic                    last,
    input  logic                    bit_in,
    input  logic [CNT_W-1:0]        idx,
    input  logic [RECIP_W-1:0]      recip,
    output logic signed [ACC_W-1:0] acc_next,
    output logic signed [ACC_W-1:0] acc_q
);
    logic signed [ACC_W-1:0] rext;
    logic signed [ACC_W-1:0] shifted;
    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] term;

    // Weighted partial product and next accumulator value.
    always_comb begin
        rext    = {{(ACC_W - RECIP_W){1'b0}}, recip};
        shifted = rext << idx;
        base    = first ? '0 : acc_q;
        if (!bit_in)
            term = '0;
        else if (last)
            term = -shifted;
        else
            term = shifted;
        acc_next = base + term;
    end

    // Accumulator register; moves only for enabled words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (acc_en)
            acc_q <= acc_next;
    end

    // R7: a gated-off word leaves the accumulator untouched.
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(acc_q));
endmodule

// File: rtl/qnt_round_sat.sv
// Module: rounding and saturation of the fixed-point product.
// Rounds to nearest with ties away from zero, then clamps to OUT_W bits signed.
// Purely combinational.
module qnt_round_sat #(
    parameter int ACC_W  = 30,
    parameter int FRAC_W = 16,
    parameter int OUT_W  = 11
) (
    input  logic signed [ACC_W-1:0] prod,
    output logic signed [OUT_W-1:0] q
);
    localparam logic [ACC_W-1:0]        HALF = ACC_W'(1) << (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) << (OUT_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic                    neg;
    logic [ACC_W-1:0]        mag;
    logic [ACC_W-1:0]        rnd;
    logic signed [ACC_W-1:0] val;

    // Work on the magnitude so a tie always goes away from zero.
    always_comb begin
        neg = prod[ACC_W-1];
        mag = neg ? ACC_W'(-prod) : ACC_W'(prod);
        rnd = (mag + HALF) >> FRAC_W;
        val = neg ? -$signed(rnd) : $signed(rnd);
        if (val > MAXV)
            q = MAXV[OUT_W-1:0];
        else if (val < MINV)
            q = MINV[OUT_W-1:0];
        else
            q = val[OUT_W-1:0];
    end

    // R4: rounding never flips the sign of the product.
    always_comb begin
        if (!$isunknown(prod)) begin
            p_sign_keep_r4: assert (!((prod < 0) && (q > 0)) && !((prod > 0) && (q < 0)));
        end
    end
endmodule

// File: rtl/qnt_serial_top.sv
// Module: bit-serial coefficient quantizer, top level.
// Sequences the 12-cycle word. It latches the position and the enable on
// word_start, drives the table and the multiplier, and registers the rounded
// result on the sign-bit cycle.
// Assumes pos_idx holds steady through a word, and that word_start marks bit 0.
module qnt_serial_top #(
    parameter int COEF_W = 12,
    parameter int FRAC_W = 16,
    parameter int OUT_W  = 11,
    parameter int POS_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_start,
    input  logic                    bit_in,
    input  logic [POS_W-1:0]        pos_idx,
    input  logic                    enable,
    output logic signed [OUT_W-1:0] q_out,
    output logic                    q_valid,
    output logic [POS_W-1:0]        q_pos
);
    localparam int RECIP_W = FRAC_W + 1;
    localparam int ACC_W   = COEF_W + RECIP_W + 1;
    localparam int CNT_W   = $clog2(COEF_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(COEF_W - 1);

    logic                    busy_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [POS_W-1:0]        pos_q;
    logic                    en_q;
    logic [CNT_W-1:0]        idx;
    logic                    active;
    logic                    last;
    logic                    en_sel;
    logic [POS_W-1:0]        pos_sel;
    logic                    acc_en;
    logic [RECIP_W-1:0]      recip;
    logic signed [ACC_W-1:0] acc_next;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [OUT_W-1:0] q_rnd;

    // Current bit weight and per-word selections.
    always_comb begin
        idx     = word_start ? '0 : cnt_q;
        active  = word_start | busy_q;
        last    = active && (idx == LAST_IDX);
        en_sel  = word_start ? enable : en_q;
        pos_sel = word_start ? pos_idx : pos_q;
        acc_en  = active && en_sel;
    end

    // Word sequencer: bit counter, busy flag, latched position and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            pos_q  <= '0;
            en_q   <= 1'b0;
        end else begin
            if (word_start) begin
                pos_q <= pos_idx;
                en_q  <= enable;
            end
            if (active) begin
                busy_q <= !last;
                cnt_q  <= last ? '0 : idx + CNT_W'(1);
            end
        end
    end

    qnt_recip_rom #(.POS_W(POS_W), .FRAC_W(FRAC_W), .RECIP_W(RECIP_W)) u_rom (
        .addr  (pos_sel),
        .recip (recip)
    );

    qnt_serial_mac #(.RECIP_W(RECIP_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .first    (word_start),
        .last     (last),
        .bit_in   (bit_in),
        .idx      (idx),
        .recip    (recip),
        .acc_next (acc_next),
        .acc_q    (acc_q)
    );

    qnt_round_sat #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_rnd (
        .prod (acc_next),
        .q    (q_rnd)
    );

    // Result register: loads on the sign-bit cycle of an enabled word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_out   <= '0;
            q_valid <= 1'b0;
            q_pos   <= '0;
        end else begin
            q_valid <= last && en_sel;
            if (last && en_sel) begin
                q_out <= q_rnd;
                q_pos <= pos_sel;
            end
        end
    end

    // R6: a strobe lasts one cycle, since a word takes twelve.
    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> !q_valid);

    // R7: the result changes only together with a strobe.
    p_hold_unless_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_out != $past(q_out)) |-> q_valid);

    // R2: the reported position is the one on the pins during the sign bit.
    p_pos_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> (q_pos == $past(pos_idx)));
endmodule

// File: tb/sim_qnt_serial_top.sv
module sim_qnt_serial_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_start = 1'b0;
    logic              bit_in = 1'b0;
    logic [5:0]        pos_idx = '0;
    logic              enable = 1'b0;
    logic signed [10:0] q_out;
    logic              q_valid;
    logic [5:0]        q_pos;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct { int val; int pos; } exp_t;
    exp_t sb[$];
    int last_val = 0;
    int last_pos = 0;

    always #10 clk = ~clk;

    qnt_serial_top u0 (
        .clk(clk), .rst_n(rst_n), .word_start(word_start), .bit_in(bit_in),
        .pos_idx(pos_idx), .enable(enable), .q_out(q_out), .q_valid(q_valid), .q_pos(q_pos)
    );

    // R3 step formula and R4/R5 rounding and saturation, written from the requirements.
    function automatic int expect_q(input int coef, input int pos);
        int  s;
        int  rc;
        longint p;
        longint m;
        longint r;
        s  = 1 + (pos / 8) + (pos % 8);
        rc = (65536 + s / 2) / s;
        p  = longint'(coef) * rc;
        m  = (p < 0) ? -p : p;
        r  = (m + 32768) / 65536;
        if (p < 0) r = -r;
        if (r > 1023) r = 1023;
        if (r < -1024) r = -1024;
        return int'(r);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: serializes one word and records the expected result when enabled.
    task automatic send(input int coef, input int pos, input bit en);
        logic [11:0] w;
        w = coef[11:0];
        if (en) sb.push_back('{val: expect_q(coef, pos), pos: pos});
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            word_start = (k == 0);
            bit_in     = w[k];
            pos_idx    = pos[5:0];
            enable     = en;
        end
    endtask

    // Idle cycles with junk on the data pins (R9).
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            word_start = 1'b0;
            bit_in     = k[0];
            pos_idx    = 6'(k * 5 + 3);
            enable     = ~k[1];
        end
    endtask

    // Monitor: pops the scoreboard on every strobe (R6, R8).
    always @(negedge clk) begin
        if (rst_n && q_valid) begin
            if (sb.size() == 0) begin
                check("R7 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check("R6 q_out", int'(q_out), e.val);
                check("R6 q_pos", int'(q_pos), e.pos);
                last_val = int'(q_out);
                last_pos = int'(q_pos);
            end
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lfsr;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 q_valid", int'(q_valid), 0);
        check("R1 q_out", int'(q_out), 0);
        check("R1 q_pos", int'(q_pos), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        check("R9 idle no change q_out", int'(q_out), 0);
        check("R9 idle no strobe seen", sb.size(), 0);

        // R4 ties and R5 saturation, directed.
        send(3, 1, 1'b1); send(-3, 1, 1'b1);      // step 2
        send(2, 3, 1'b1); send(-2, 3, 1'b1);      // step 4
        send(2047, 0, 1'b1); send(-2048, 0, 1'b1); send(-2047, 0, 1'b1);
        send(0, 10, 1'b1); send(-1, 63, 1'b1); send(1, 0, 1'b1);
        idle(4);

        // R7: skipped word keeps the outputs.
        send(777, 12, 1'b1);
        send(-500, 20, 1'b0);
        idle(3);
        check("R7 hold q_out", int'(q_out), last_val);
        check("R7 hold q_pos", int'(q_pos), last_pos);
        check("R7 pending empty", sb.size(), 0);

        // R8 back to back and R2 format over all positions, with gaps and skips.
        lfsr = 32'h1ACE;
        for (int i = 0; i < 192; i++) begin
            int c;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            c = (lfsr % 4096) - 2048;
            send(c, i % 64, (i % 7) != 3);
            if ((i % 11) == 5) idle(2);
        end
        idle(4);
        check("R8 scoreboard drained", sb.size(), 0);
        check("R7 final hold q_out", int'(q_out), last_val);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule